// File: doc/BRIEF.md
# Dual-Lane DDR Sensor Frame Receiver

This block sits on the acquisition side of a zero-suppressed pixel-sensor link. The sensor forwards a 160 MHz clock and drives one or two serial lanes that change on both edges. Each lane therefore moves 320 Mb/s, one bit every 3.125 ns. The pad-side double-data-rate capture stage is outside this block. It hands over one bit taken on the rising edge and one taken on the falling edge, per lane, on every cycle of the forwarded clock, and that clock also runs this block. The receiver turns each lane's bit pairs into 30-bit words, least significant bit first. It then walks a fixed frame envelope on every lane: a header word, a trigger word, a word that packs the frame counter and the payload length, the payload words, and a trailer word.

A frame-marker line, high in the cycle that carries the first header bit, aligns the receiver while it is idle. Header and trailer patterns come from programmable compare inputs. A mode input selects single-lane operation (lane 0 only) or dual-lane operation (both lanes in lockstep, 640 Mb/s in total). A grade input selects the payload ceiling per lane: 416 words for the long-readout grade and 208 for the short-readout grade, matching frame periods of 41.6 µs and 20.8 µs. The receiver presents the decoded service fields with a one-cycle strobe, then the payload words with start and end flags, and raises a pulse when a frame closes cleanly or when a sync or length error is found.

Top module: `sfr_frame_rx`

## Requirements
- R1: A word collects 15 clock cycles of one lane. The rising-edge bit of cycle k becomes bit 2k and the falling-edge bit becomes bit 2k+1, so the first bit after the marker is the word's least significant bit.
- R2: A marker starts a frame only while the receiver is idle, or in the cycle in which it finishes a frame. A marker that arrives in the middle of a frame leaves that frame's outputs unchanged.
- R3: If lane 0's first word differs from the lane-0 header pattern, or dual mode is on and lane 1's first word differs from the lane-1 header pattern, then err_sync pulses for one cycle. The receiver then produces no meta strobe and no payload for that frame and waits for a new marker.
- R4: The third word of lane 0 holds the frame counter in bits [29:10] and the length in bits [9:0]. When that length is accepted, meta_vld pulses for one cycle with the lane-0 second word (trigger), the counter and the length. The pulse comes before the first payload word of the frame and also comes when the length is zero.
- R5: Payload words leave in stream order with pay_vld. pay_sof marks the first word and pay_eof marks the last. In single-lane mode every word is tagged lane 0, and nothing on lane 1 affects any output.
- R6: In dual mode each lane-0 payload word is followed in the next cycle by the lane-1 word from the same slot, tagged lane 1, and pay_eof sits on the final lane-1 word. If the two lanes' length fields differ, err_len pulses and the frame is dropped with no meta strobe and no payload.
- R7: A length above 416 (grade_short low) or above 208 (grade_short high) pulses err_len, produces no meta strobe and no payload, and sends the receiver back to waiting. A length equal to the ceiling is accepted.
- R8: The word after the last payload word is compared with the trailer pattern on each active lane. A match pulses frame_ok. A mismatch pulses err_len instead, and no frame_ok is given.
- R9: A marker in the cycle right after a frame's last trailer bit starts the next frame with no idle gap.
- R10: During and after reset, every strobe and flag output is low and the receiver waits for a marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded 160 MHz link clock |
| rst | input | 1 | Synchronous active-high reset |
| dual_en | input | 1 | 1 selects two-lane operation; sampled at frame start |
| grade_short | input | 1 | 1 selects the 208-word ceiling, 0 the 416-word ceiling; sampled at frame start |
| hdr_pat0 | input | 30 | Expected header word on lane 0 |
| hdr_pat1 | input | 30 | Expected header word on lane 1 |
| tlr_pat0 | input | 30 | Expected trailer word on lane 0 |
| tlr_pat1 | input | 30 | Expected trailer word on lane 1 |
| mark | input | 1 | Frame marker, high in the cycle of the first header bit |
| d_rise | input | 2 | Rising-edge bit per lane (bit 0 = lane 0) |
| d_fall | input | 2 | Falling-edge bit per lane (bit 0 = lane 0) |
| pay_vld | output | 1 | Payload word valid |
| pay_data | output | 30 | Payload word |
| pay_lane | output | 1 | Lane that carried the payload word |
| pay_sof | output | 1 | First payload word of a frame |
| pay_eof | output | 1 | Last payload word of a frame |
| meta_vld | output | 1 | Service fields valid (one cycle) |
| meta_trig | output | 30 | Trigger word |
| meta_fcnt | output | 20 | Frame counter |
| meta_len | output | 10 | Payload words per lane |
| frame_ok | output | 1 | Trailer matched, frame complete |
| err_sync | output | 1 | Header mismatch |
| err_len | output | 1 | Length over ceiling, lane length disagreement or misplaced trailer |

## Verification
The hardest condition to reach is a frame boundary that lands exactly where the previous frame ends. In that case the next marker shares its cycle with the trailer decision, or with the hunt that follows an error. The bench sends frames with a zero-cycle gap in a chain that mixes single-lane, dual-lane and bad-header frames, and checks every payload word and service field of each one. Frames at exactly 208 and 416 payload words, one word over each ceiling, and frames that carry a stray marker in the middle are sent on purpose. Seeded random frames then vary the mode, grade, length, lane-1 content and error kind.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // Parser position inside the frame envelope
  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_TRG,
    ST_LEN,
    ST_PAY,
    ST_TLR
  } rx_state_t;

endpackage

// File: rtl/sfr_lane_deser.sv
// One lane: two bits per cycle (rising edge first), LSB-first word assembly.
module sfr_lane_deser #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              bit_r,
  input  logic              bit_f,
  output logic [WORD_W-1:0] word,
  output logic              word_vld
);
  localparam int CYC = WORD_W / 2;
  localparam int CW  = $clog2(CYC);

  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_nx;

  // New bits enter at the top; after CYC shifts the oldest pair sits at [1:0]
  assign sh_nx = {bit_f, bit_r, sh[WORD_W-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sh       <= '0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      if (!run) begin
        cnt <= '0;
      end else begin
        sh <= sh_nx;
        if (cnt == CW'(CYC - 1)) begin
          cnt      <= '0;
          word     <= sh_nx;
          word_vld <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sfr_frame_parser.sv
// Walks header, trigger, count/length, payload and trailer on lockstep lanes.
module sfr_frame_parser
  import sfr_pkg::*;
#(
  parameter int WORD_W     = 30,
  parameter int LEN_W      = 10,
  parameter int CEIL_LONG  = 416,
  parameter int CEIL_SHORT = 208
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dual_en,
  input  logic                    grade_short,
  input  logic [WORD_W-1:0]       hdr_pat0,
  input  logic [WORD_W-1:0]       hdr_pat1,
  input  logic [WORD_W-1:0]       tlr_pat0,
  input  logic [WORD_W-1:0]       tlr_pat1,
  input  logic                    mark,
  input  logic [WORD_W-1:0]       w0,
  input  logic [WORD_W-1:0]       w1,
  input  logic                    wv,
  output logic                    arm,
  output logic                    pay_vld,
  output logic [WORD_W-1:0]       pay_data,
  output logic                    pay_lane,
  output logic                    pay_sof,
  output logic                    pay_eof,
  output logic                    meta_vld,
  output logic [WORD_W-1:0]       meta_trig,
  output logic [WORD_W-LEN_W-1:0] meta_fcnt,
  output logic [LEN_W-1:0]        meta_len,
  output logic                    frame_ok,
  output logic                    err_sync,
  output logic                    err_len
);
  localparam logic [LEN_W-1:0] CL = LEN_W'(CEIL_LONG);
  localparam logic [LEN_W-1:0] CS = LEN_W'(CEIL_SHORT);

  rx_state_t         state;
  logic              dual_q;
  logic              grade_q;
  logic [LEN_W-1:0]  remain;
  logic              first;
  logic [WORD_W-1:0] trig_q;
  logic [WORD_W-1:0] l1_hold;
  logic              l1_pend;
  logic              l1_last;

  logic             hdr_bad;
  logic             tlr_bad;
  logic             len_bad;
  logic             to_hunt;
  logic             last;
  logic [LEN_W-1:0] len0;
  logic [LEN_W-1:0] ceil_sel;

  always_comb begin
    len0     = w0[LEN_W-1:0];
    ceil_sel = grade_q ? CS : CL;
    hdr_bad  = (w0 != hdr_pat0) | (dual_q & (w1 != hdr_pat1));
    tlr_bad  = (w0 != tlr_pat0) | (dual_q & (w1 != tlr_pat1));
    len_bad  = (len0 > ceil_sel) | (dual_q & (w1[LEN_W-1:0] != len0));
    last     = (remain == LEN_W'(1));
    to_hunt  = wv & (((state == ST_HDR) & hdr_bad) |
                     ((state == ST_LEN) & len_bad) |
                     (state == ST_TLR));
    arm      = (state == ST_HUNT) | to_hunt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HUNT;
      dual_q    <= 1'b0;
      grade_q   <= 1'b0;
      remain    <= '0;
      first     <= 1'b0;
      trig_q    <= '0;
      l1_hold   <= '0;
      l1_pend   <= 1'b0;
      l1_last   <= 1'b0;
      pay_vld   <= 1'b0;
      pay_data  <= '0;
      pay_lane  <= 1'b0;
      pay_sof   <= 1'b0;
      pay_eof   <= 1'b0;
      meta_vld  <= 1'b0;
      meta_trig <= '0;
      meta_fcnt <= '0;
      meta_len  <= '0;
      frame_ok  <= 1'b0;
      err_sync  <= 1'b0;
      err_len   <= 1'b0;
    end else begin
      pay_vld  <= 1'b0;
      pay_sof  <= 1'b0;
      pay_eof  <= 1'b0;
      meta_vld <= 1'b0;
      frame_ok <= 1'b0;
      err_sync <= 1'b0;
      err_len  <= 1'b0;

      if (arm) begin
        dual_q  <= dual_en;
        grade_q <= grade_short;
      end

      // Second half of a dual-lane slot leaves one cycle after the first
      if (l1_pend) begin
        pay_vld  <= 1'b1;
        pay_data <= l1_hold;
        pay_lane <= 1'b1;
        pay_eof  <= l1_last;
        l1_pend  <= 1'b0;
      end

      case (state)
        ST_HUNT: if (mark) state <= ST_HDR;
        ST_HDR: if (wv) begin
          if (hdr_bad) begin
            err_sync <= 1'b1;
            state    <= mark ? ST_HDR : ST_HUNT;
          end else begin
            state <= ST_TRG;
          end
        end
        ST_TRG: if (wv) begin
          trig_q <= w0;
          state  <= ST_LEN;
        end
        ST_LEN: if (wv) begin
          if (len_bad) begin
            err_len <= 1'b1;
            state   <= mark ? ST_HDR : ST_HUNT;
          end else begin
            meta_vld  <= 1'b1;
            meta_trig <= trig_q;
            meta_fcnt <= w0[WORD_W-1:LEN_W];
            meta_len  <= len0;
            remain    <= len0;
            first     <= 1'b1;
            state     <= (len0 == '0) ? ST_TLR : ST_PAY;
          end
        end
        ST_PAY: if (wv) begin
          pay_vld  <= 1'b1;
          pay_data <= w0;
          pay_lane <= 1'b0;
          pay_sof  <= first;
          pay_eof  <= last & ~dual_q;
          first    <= 1'b0;
          if (dual_q) begin
            l1_hold <= w1;
            l1_pend <= 1'b1;
            l1_last <= last;
          end
          remain <= remain - 1'b1;
          if (last) state <= ST_TLR;
        end
        ST_TLR: if (wv) begin
          if (tlr_bad) err_len  <= 1'b1;
          else         frame_ok <= 1'b1;
          state <= mark ? ST_HDR : ST_HUNT;
        end
        default: state <= ST_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/sfr_frame_rx.sv
module sfr_frame_rx #(
  parameter int WORD_W     = 30,
  parameter int LEN_W      = 10,
  parameter int CEIL_LONG  = 416,
  parameter int CEIL_SHORT = 208
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    dual_en,
  input  logic                    grade_short,
  input  logic [WORD_W-1:0]       hdr_pat0,
  input  logic [WORD_W-1:0]       hdr_pat1,
  input  logic [WORD_W-1:0]       tlr_pat0,
  input  logic [WORD_W-1:0]       tlr_pat1,
  input  logic                    mark,
  input  logic [1:0]              d_rise,
  input  logic [1:0]              d_fall,
  output logic                    pay_vld,
  output logic [WORD_W-1:0]       pay_data,
  output logic                    pay_lane,
  output logic                    pay_sof,
  output logic                    pay_eof,
  output logic                    meta_vld,
  output logic [WORD_W-1:0]       meta_trig,
  output logic [WORD_W-LEN_W-1:0] meta_fcnt,
  output logic [LEN_W-1:0]        meta_len,
  output logic                    frame_ok,
  output logic                    err_sync,
  output logic                    err_len
);
  localparam int LANES = 2;

  logic [WORD_W-1:0] lw [LANES];
  logic [LANES-1:0]  lv;
  logic              arm;
  logic              run;

  // Deserializers idle while hunting unless a marker opens a frame
  assign run = ~arm | mark;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sfr_lane_deser #(.WORD_W(WORD_W)) u_deser (
      .clk      (clk),
      .rst      (rst),
      .run      (run),
      .bit_r    (d_rise[g]),
      .bit_f    (d_fall[g]),
      .word     (lw[g]),
      .word_vld (lv[g])
    );
  end

  sfr_frame_parser #(
    .WORD_W     (WORD_W),
    .LEN_W      (LEN_W),
    .CEIL_LONG  (CEIL_LONG),
    .CEIL_SHORT (CEIL_SHORT)
  ) u_parser (
    .clk         (clk),
    .rst         (rst),
    .dual_en     (dual_en),
    .grade_short (grade_short),
    .hdr_pat0    (hdr_pat0),
    .hdr_pat1    (hdr_pat1),
    .tlr_pat0    (tlr_pat0),
    .tlr_pat1    (tlr_pat1),
    .mark        (mark),
    .w0          (lw[0]),
    .w1          (lw[1]),
    .wv          (&lv),
    .arm         (arm),
    .pay_vld     (pay_vld),
    .pay_data    (pay_data),
    .pay_lane    (pay_lane),
    .pay_sof     (pay_sof),
    .pay_eof     (pay_eof),
    .meta_vld    (meta_vld),
    .meta_trig   (meta_trig),
    .meta_fcnt   (meta_fcnt),
    .meta_len    (meta_len),
    .frame_ok    (frame_ok),
    .err_sync    (err_sync),
    .err_len     (err_len)
  );

endmodule

// File: rtl/sfr_rx_checker.sv
module sfr_rx_checker #(
  parameter int LEN_W      = 10,
  parameter int CEIL_LONG  = 416,
  parameter int CEIL_SHORT = 208
) (
  input logic             clk,
  input logic             rst,
  input logic             dual_en,
  input logic             grade_short,
  input logic             pay_vld,
  input logic             pay_lane,
  input logic             pay_sof,
  input logic             pay_eof,
  input logic             meta_vld,
  input logic [LEN_W-1:0] meta_len,
  input logic             frame_ok,
  input logic             err_sync,
  input logic             err_len
);
  logic meta_seen;

  always_ff @(posedge clk) begin
    if (rst)           meta_seen <= 1'b0;
    else if (meta_vld) meta_seen <= 1'b1;
    else if (pay_eof)  meta_seen <= 1'b0;
  end

  p_err_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(err_sync && err_len));

  p_sof_after_meta_r4: assert property (@(posedge clk) disable iff (rst)
    pay_sof |-> meta_seen);

  p_meta_gap_r4: assert property (@(posedge clk) disable iff (rst)
    meta_vld |=> !pay_vld);

  p_single_lane0_r5: assert property (@(posedge clk) disable iff (rst)
    (pay_vld && !dual_en) |-> !pay_lane);

  p_flags_on_vld_r5: assert property (@(posedge clk) disable iff (rst)
    (pay_sof || pay_eof) |-> pay_vld);

  p_dual_pair_r6: assert property (@(posedge clk) disable iff (rst)
    (pay_vld && !pay_lane && dual_en) |=> (pay_vld && pay_lane));

  p_len_ceiling_r7: assert property (@(posedge clk) disable iff (rst)
    meta_vld |-> (meta_len <= (grade_short ? LEN_W'(CEIL_SHORT) : LEN_W'(CEIL_LONG))));

  p_ok_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    frame_ok |=> !frame_ok);

endmodule

bind sfr_frame_rx sfr_rx_checker #(
  .LEN_W      (LEN_W),
  .CEIL_LONG  (CEIL_LONG),
  .CEIL_SHORT (CEIL_SHORT)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dual_en     (dual_en),
  .grade_short (grade_short),
  .pay_vld     (pay_vld),
  .pay_lane    (pay_lane),
  .pay_sof     (pay_sof),
  .pay_eof     (pay_eof),
  .meta_vld    (meta_vld),
  .meta_len    (meta_len),
  .frame_ok    (frame_ok),
  .err_sync    (err_sync),
  .err_len     (err_len)
);

// File: tb/test_sfr_frame_rx.sv
`timescale 1ns/1ps
module test_sfr_frame_rx;
  localparam logic [29:0] HDR0 = 30'h1A5C3F0E;
  localparam logic [29:0] HDR1 = 30'h2E1790B3;
  localparam logic [29:0] TLR0 = 30'h0B7D44A1;
  localparam logic [29:0] TLR1 = 30'h3C02E6D9;

  logic        clk = 1'b0;
  logic        rst;
  logic        dual_en, grade_short, mark;
  logic [1:0]  d_rise, d_fall;
  logic        pay_vld, pay_lane, pay_sof, pay_eof, meta_vld;
  logic        frame_ok, err_sync, err_len;
  logic [29:0] pay_data, meta_trig;
  logic [19:0] meta_fcnt;
  logic [9:0]  meta_len;

  always #2.5 clk = ~clk;

  sfr_frame_rx i_sfr_frame_rx (
    .clk(clk), .rst(rst), .dual_en(dual_en), .grade_short(grade_short),
    .hdr_pat0(HDR0), .hdr_pat1(HDR1), .tlr_pat0(TLR0), .tlr_pat1(TLR1),
    .mark(mark), .d_rise(d_rise), .d_fall(d_fall),
    .pay_vld(pay_vld), .pay_data(pay_data), .pay_lane(pay_lane),
    .pay_sof(pay_sof), .pay_eof(pay_eof), .meta_vld(meta_vld),
    .meta_trig(meta_trig), .meta_fcnt(meta_fcnt), .meta_len(meta_len),
    .frame_ok(frame_ok), .err_sync(err_sync), .err_len(err_len)
  );

  logic [29:0] fw0 [0:423];
  logic [29:0] fw1 [0:423];
  logic [32:0] exp_pay[$], obs_pay[$];
  logic [59:0] exp_meta[$], obs_meta[$];
  int e_ok, e_es, e_el, o_ok, o_es, o_el;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit meta_pend;

  task automatic chk(bit good, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Output monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (!rst) begin
      if (pay_vld) begin
        obs_pay.push_back({pay_lane, pay_sof, pay_eof, pay_data});
        if (pay_sof) begin
          chk(meta_pend, "R4", "meta strobe ahead of first payload", 64'(meta_pend), 64'd1);
          meta_pend = 1'b0;
        end
      end
      if (meta_vld) begin
        obs_meta.push_back({meta_trig, meta_fcnt, meta_len});
        meta_pend = 1'b1;
      end
      if (frame_ok) o_ok++;
      if (err_sync) o_es++;
      if (err_len)  o_el++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mark   = 1'b0;
      d_rise = 2'($urandom);
      d_fall = 2'($urandom);
    end
  endtask

  task automatic send_words(int nw, int stray, bit dual, bit grade);
    for (int k = 0; k < nw; k++) begin
      for (int c = 0; c < 15; c++) begin
        @(negedge clk);
        if (k == 0 && c == 0) begin
          dual_en     = dual;
          grade_short = grade;
        end
        mark   = (c == 0) && (k == 0 || k == stray);
        d_rise = {fw1[k][2*c], fw0[k][2*c]};
        d_fall = {fw1[k][2*c+1], fw0[k][2*c+1]};
      end
    end
  endtask

  // kind: 0 good, 1 bad lane-0 header, 2 bad lane-1 header, 3 unused,
  //       4 bad trailer, 5 lane length mismatch, 6 stray marker mid-frame
  task automatic send_frame(int len, bit dual, bit grade, int kind);
    int ceil_v;
    int nw;
    bit tl1;
    logic [29:0] trig;
    logic [19:0] fc;
    logic [9:0]  lf;
    ceil_v = grade ? 208 : 416;
    lf   = 10'(len);
    fc   = 20'($urandom);
    trig = 30'($urandom);
    tl1  = 1'($urandom);
    fw0[0] = (kind == 1) ? (HDR0 ^ 30'h1) : HDR0;
    fw1[0] = !dual ? 30'($urandom) : ((kind == 2) ? (HDR1 ^ 30'h4) : HDR1);
    fw0[1] = trig;
    fw1[1] = 30'($urandom);
    fw0[2] = {fc, lf};
    fw1[2] = !dual ? 30'($urandom) : {20'($urandom), (kind == 5) ? lf + 10'd1 : lf};
    nw = (len > ceil_v) ? 5 : len + 4;
    for (int k = 0; k < len && k < 420; k++) begin
      fw0[3+k] = 30'($urandom);
      fw1[3+k] = 30'($urandom);
    end
    if (len <= ceil_v) begin
      fw0[3+len] = (kind == 4 && !tl1) ? (TLR0 ^ 30'h20000000) : TLR0;
      fw1[3+len] = !dual ? 30'($urandom) : ((kind == 4 && tl1) ? (TLR1 ^ 30'h2) : TLR1);
    end
    // expected outcome from the requirements
    if (kind == 1 || (kind == 2 && dual)) e_es++;
    else if (len > ceil_v || (kind == 5 && dual)) e_el++;
    else begin
      exp_meta.push_back({trig, fc, lf});
      for (int k = 0; k < len; k++) begin
        exp_pay.push_back({1'b0, k == 0, (k == len - 1) && !dual, fw0[3+k]});
        if (dual) exp_pay.push_back({1'b1, 1'b0, k == len - 1, fw1[3+k]});
      end
      if (kind == 4 && (dual || !tl1)) e_el++;
      else e_ok++;
    end
    send_words(nw, (kind == 6) ? 3 + len / 2 : -1, dual, grade);
  endtask

  task automatic compare(string tag);
    int n;
    idle(8);
    chk(obs_pay.size() == exp_pay.size(), "R5", {tag, " payload count"},
        64'(obs_pay.size()), 64'(exp_pay.size()));
    n = (obs_pay.size() < exp_pay.size()) ? obs_pay.size() : exp_pay.size();
    for (int i = 0; i < n; i++)
      chk(obs_pay[i] == exp_pay[i], "R1 R5", {tag, " payload word {lane,sof,eof,data}"},
          64'(obs_pay[i]), 64'(exp_pay[i]));
    chk(obs_meta.size() == exp_meta.size(), "R4", {tag, " meta count"},
        64'(obs_meta.size()), 64'(exp_meta.size()));
    n = (obs_meta.size() < exp_meta.size()) ? obs_meta.size() : exp_meta.size();
    for (int i = 0; i < n; i++)
      chk(obs_meta[i] == exp_meta[i], "R4", {tag, " meta {trig,fcnt,len}"},
          64'(obs_meta[i]), 64'(exp_meta[i]));
    chk(o_ok == e_ok, "R8", {tag, " frame_ok pulses"}, 64'(o_ok), 64'(e_ok));
    chk(o_es == e_es, "R3", {tag, " err_sync pulses"}, 64'(o_es), 64'(e_es));
    chk(o_el == e_el, "R7", {tag, " err_len pulses"}, 64'(o_el), 64'(e_el));
    obs_pay.delete(); exp_pay.delete(); obs_meta.delete(); exp_meta.delete();
    e_ok = 0; e_es = 0; e_el = 0; o_ok = 0; o_es = 0; o_el = 0;
    meta_pend = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; dual_en = 1'b0; grade_short = 1'b0; mark = 1'b0;
    d_rise = 2'b11; d_fall = 2'b11;
    e_ok = 0; e_es = 0; e_el = 0; o_ok = 0; o_es = 0; o_el = 0;
    meta_pend = 1'b0;
    repeat (4) @(negedge clk);
    chk(!pay_vld && !meta_vld, "R10", "reset strobes", {62'd0, pay_vld, meta_vld}, 64'd0);
    chk(!frame_ok && !err_sync && !err_len, "R10", "reset flags",
        {61'd0, frame_ok, err_sync, err_len}, 64'd0);
    @(negedge clk); rst = 1'b0;
    idle(20);
    compare("R10 idle after reset, no marker");

    send_frame(3, 0, 0, 0);   compare("R1 R5 single len3");
    send_frame(5, 1, 0, 0);   compare("R6 dual len5");
    send_frame(0, 0, 1, 0);   compare("R4 len0");
    send_frame(4, 1, 0, 0);   compare("R6 dual len4 single-word check");
    send_frame(4, 0, 0, 1);   compare("R3 bad lane0 header");
    send_frame(4, 1, 1, 2);   compare("R3 R6 bad lane1 header");
    send_frame(4, 0, 0, 2);   compare("R5 lane1 ignored in single mode");
    send_frame(208, 1, 1, 0); compare("R7 short grade at ceiling");
    send_frame(209, 0, 1, 0); compare("R7 short grade over ceiling");
    send_frame(416, 0, 0, 0); compare("R7 long grade at ceiling");
    send_frame(417, 1, 0, 0); compare("R7 long grade over ceiling");
    send_frame(6, 0, 0, 4);   compare("R8 bad trailer single");
    send_frame(6, 1, 0, 4);   compare("R8 bad trailer dual");
    send_frame(5, 1, 1, 5);   compare("R6 lane length mismatch");
    send_frame(8, 0, 0, 6);   compare("R2 stray marker single");
    send_frame(6, 1, 1, 6);   compare("R2 stray marker dual");

    // R9: frames abutting with no idle cycle
    send_frame(3, 0, 0, 0);
    send_frame(2, 1, 1, 0);
    send_frame(3, 0, 0, 1);
    send_frame(4, 1, 0, 0);
    send_frame(0, 0, 1, 0);
    send_frame(2, 0, 0, 4);
    send_frame(3, 1, 0, 0);
    compare("R9 back-to-back chain");

    for (int f = 0; f < 40; f++) begin
      int kind;
      kind = int'($urandom % 10);
      if (kind > 6 || kind == 3) kind = 0;
      send_frame(int'($urandom % 14), 1'($urandom), 1'($urandom), kind);
      if ($urandom % 3 != 0) compare("random frame");
    end
    compare("random tail");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule